// File: doc/BRIEF.md
# Low-Power Entry Sequencer

This block decides whether a processor's wait-for-interrupt turns into a real low-power entry, and it controls how the chip leaves that state again. A sleep attempt begins only when the processor is waiting and software has set the low-power hint. It then goes through a one-cycle qualification step. In that step a just-arrived interrupt makes the attempt fall through. An active debug session vetoes the attempt. A busy nonvolatile-memory, lifecycle or fuse controller aborts it. Both fall-through and abort return to the active state without touching the clocks.

When entry proceeds, the core clock is gated and the block sleeps. In deep sleep it also drops the peripheral clock and main power. Only an enabled wake source can end sleep. The enabled sources that woke the block are latched as the wake cause, and a one-cycle pulse tells software to clear its hint. An enabled reset request, or loss of main power-ok, sends the sequencer to a reset state from anywhere and records the cause. The block leaves the reset state once power is good and no enabled request remains.

Top module: `lp_sequencer`

## Requirements
- R1: After reset the core clock enable, peripheral clock enable and power enable are 1, reset_req and hint_clr are 0, and both cause registers are 0.
- R2: cpu_wfi with lp_hint at 0 never gates the core clock.
- R3: While debug_active is 1, either in the request cycle or in the qualification cycle, entry is vetoed and the core clock stays on.
- R4: If irq_pending is 1 in the qualification cycle, the sleep falls through to active with the core clock still on.
- R5: If any of nvm_busy, lc_busy or fuse_busy is 1 in the qualification cycle, entry aborts to active with the core clock still on.
- R6: With cpu_wfi and lp_hint both 1 in cycle n and no veto, abort or fall-through in cycle n+1, core_clk_en is 0 from cycle n+2. During sleep, io_clk_en and pwr_en are 0 only if deep_sel was 1 in the qualification cycle.
- R7: In sleep, a wake happens only when wake_req & wake_en is nonzero. Bit i of wake_cause is then loaded with wake source i's masked request. Otherwise the block stays asleep and wake_cause keeps its value.
- R8: Wake raises hint_clr for exactly one cycle, in which the core clock is still gated. The core clock is back on in the next cycle.
- R9: An enabled reset request (rst_req & rst_en nonzero) sets reset_req in the next cycle with the core clock on. reset_cause bits [NRST-1:0] then hold the masked requests and bit NRST holds 0. A request whose enable is clear has no effect.
- R10: A reset request arriving during a sleep attempt (qualification, entry or sleep) takes over. Once the request clears, the block returns to active and can sleep again.
- R11: main_pok at 0 in any state sets reset_req in the next cycle and loads reset_cause with only bit NRST (power fault) set. reset_req holds until main_pok returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wfi | input | 1 | Processor waiting for interrupt |
| lp_hint | input | 1 | Software low-power hint |
| deep_sel | input | 1 | 1 selects deep sleep, 0 selects normal sleep |
| wake_req | input | NWAKE | Per-source wake requests |
| wake_en | input | NWAKE | Per-source wake enables |
| rst_req | input | NRST | Per-source reset requests |
| rst_en | input | NRST | Per-source reset enables |
| debug_active | input | 1 | Debug session in progress |
| nvm_busy | input | 1 | Nonvolatile-memory transaction in progress |
| lc_busy | input | 1 | Lifecycle transaction in progress |
| fuse_busy | input | 1 | Fuse controller transaction in progress |
| irq_pending | input | 1 | Interrupt pending at the processor |
| main_pok | input | 1 | Main supply power-ok |
| core_clk_en | output | 1 | Core clock enable |
| io_clk_en | output | 1 | Peripheral clock enable |
| pwr_en | output | 1 | Main power domain enable |
| reset_req | output | 1 | Reset request to the reset tree |
| hint_clr | output | 1 | One-cycle pulse to clear the low-power hint |
| wake_cause | output | NWAKE | Latched masked wake sources |
| reset_cause | output | NRST+1 | Latched masked reset sources, top bit power fault |

## Verification
The hardest situations to reach are events that land inside the single qualification cycle, and power loss in the short-lived entry and wake states. The stimulus drives the wait and hint for exactly one cycle. It then applies every combination of interrupt, debug and the three busy flags in the following cycle, and checks the core clock one edge later. Power loss is injected after walking the sequencer a counted number of cycles into each state, including the one-cycle entry and wake states. The wake masks and the reset masks are swept exhaustively against their request patterns.

// File: rtl/lp_sequencer.sv
module lp_sequencer #(
  parameter int NWAKE = 4,
  parameter int NRST  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wfi,
  input  logic             lp_hint,
  input  logic             deep_sel,
  input  logic [NWAKE-1:0] wake_req,
  input  logic [NWAKE-1:0] wake_en,
  input  logic [NRST-1:0]  rst_req,
  input  logic [NRST-1:0]  rst_en,
  input  logic             debug_active,
  input  logic             nvm_busy,
  input  logic             lc_busy,
  input  logic             fuse_busy,
  input  logic             irq_pending,
  input  logic             main_pok,
  output logic             core_clk_en,
  output logic             io_clk_en,
  output logic             pwr_en,
  output logic             reset_req,
  output logic             hint_clr,
  output logic [NWAKE-1:0] wake_cause,
  output logic [NRST:0]    reset_cause
);
  typedef enum logic [2:0] {S_ACT, S_CHK, S_ENT, S_SLP, S_WAK, S_RST} st_t;
  st_t st;
  logic deep_q;

  wire [NWAKE-1:0] wake_hit = wake_req & wake_en;
  wire [NRST-1:0]  rst_hit  = rst_req & rst_en;
  wire blocked = irq_pending | debug_active | nvm_busy | lc_busy | fuse_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_ACT;
      deep_q      <= 1'b0;
      wake_cause  <= '0;
      reset_cause <= '0;
    end else if (!main_pok) begin
      st          <= S_RST;
      reset_cause <= {1'b1, {NRST{1'b0}}};
    end else if (|rst_hit && st != S_RST) begin
      st          <= S_RST;
      reset_cause <= {1'b0, rst_hit};
    end else begin
      case (st)
        S_ACT: if (cpu_wfi && lp_hint && !debug_active) st <= S_CHK;
        S_CHK: begin
          if (blocked) st <= S_ACT;
          else begin
            st     <= S_ENT;
            deep_q <= deep_sel;
          end
        end
        S_ENT: st <= S_SLP;
        S_SLP: if (|wake_hit) begin
          st         <= S_WAK;
          wake_cause <= wake_hit;
        end
        S_WAK: st <= S_ACT;
        S_RST: if (!(|rst_hit)) st <= S_ACT;
        default: st <= S_ACT;
      endcase
    end
  end

  assign core_clk_en = !(st == S_ENT || st == S_SLP || st == S_WAK);
  assign io_clk_en   = !(st == S_SLP && deep_q);
  assign pwr_en      = !(st == S_SLP && deep_q);
  assign reset_req   = (st == S_RST);
  assign hint_clr    = (st == S_WAK);

  // R6
  entry_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clk_en) |-> ($past(cpu_wfi, 2) && $past(lp_hint, 2) &&
                            !$past(irq_pending) && !$past(debug_active)));
  // R8
  hint_clr_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hint_clr |-> (!core_clk_en ##1 core_clk_en));
  // R7
  wake_cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wake_cause) |-> hint_clr);
  // R9
  reset_clk_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> core_clk_en);
  // R10
  reset_takeover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rst_req & rst_en)) |=> reset_req);
  // R11
  pok_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !main_pok |=> (reset_req && reset_cause[NRST]));
endmodule

// File: tb/lp_sequencer_test.sv
`timescale 1ns/1ps
module lp_sequencer_test;
  localparam int NW = 4;
  localparam int NR = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_wfi = 0, lp_hint = 0, deep_sel = 0, debug_active = 0;
  logic nvm_busy = 0, lc_busy = 0, fuse_busy = 0, irq_pending = 0, main_pok = 1;
  logic [NW-1:0] wake_req = '0, wake_en = '0;
  logic [NR-1:0] rst_req = '0, rst_en = '0;
  logic core_clk_en, io_clk_en, pwr_en, reset_req, hint_clr;
  logic [NW-1:0] wake_cause;
  logic [NR:0] reset_cause;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [NW-1:0] exp_wc;
  logic [NR:0] exp_rc;

  always #2.5 clk = ~clk;

  lp_sequencer #(.NWAKE(NW), .NRST(NR)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_wfi(cpu_wfi), .lp_hint(lp_hint), .deep_sel(deep_sel),
    .wake_req(wake_req), .wake_en(wake_en), .rst_req(rst_req), .rst_en(rst_en),
    .debug_active(debug_active), .nvm_busy(nvm_busy), .lc_busy(lc_busy),
    .fuse_busy(fuse_busy), .irq_pending(irq_pending), .main_pok(main_pok),
    .core_clk_en(core_clk_en), .io_clk_en(io_clk_en), .pwr_en(pwr_en),
    .reset_req(reset_req), .hint_clr(hint_clr), .wake_cause(wake_cause),
    .reset_cause(reset_cause));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic go_sleep(logic deep);
    cpu_wfi = 1; lp_hint = 1; deep_sel = deep;
    tick();
    cpu_wfi = 0;
    tick();
    tick();
  endtask

  task automatic wake0();
    wake_req = 4'b0001; wake_en = 4'b0001;
    tick();
    wake_req = '0; wake_en = '0; lp_hint = 0; exp_wc = 4'b0001;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    exp_wc = '0; exp_rc = '0;
    tick(); tick();
    rst_n = 1;
    tick();
    // R1
    chk("R1 clocks", {core_clk_en, io_clk_en, pwr_en}, 3'b111);
    chk("R1 flags", {reset_req, hint_clr}, 2'b00);
    chk("R1 causes", {wake_cause, reset_cause}, '0);

    // R2: wfi without hint
    cpu_wfi = 1; lp_hint = 0;
    tick(); tick(); tick();
    chk("R2 no entry", core_clk_en, 1);
    cpu_wfi = 0;

    // R3: debug at request
    debug_active = 1; cpu_wfi = 1; lp_hint = 1;
    tick(); cpu_wfi = 0; tick();
    chk("R3 veto at request", core_clk_en, 1);
    debug_active = 0; lp_hint = 0; tick();

    // R3 R4 R5: every combination in the qualification cycle
    for (int m = 0; m < 32; m++) begin
      cpu_wfi = 1; lp_hint = 1; deep_sel = 0;
      tick();
      cpu_wfi = 0;
      {debug_active, irq_pending, nvm_busy, lc_busy, fuse_busy} = m[4:0];
      tick();
      {debug_active, irq_pending, nvm_busy, lc_busy, fuse_busy} = '0;
      if (m[4]) chk("R3 veto in check", core_clk_en, 1);
      else if (m[3]) chk("R4 fall through", core_clk_en, 1);
      else if (m != 0) chk("R5 busy abort", core_clk_en, 1);
      else chk("R6 entry gates core", core_clk_en, 0);
      if (m == 0) begin
        tick(); wake0();
      end else begin
        lp_hint = 0; tick();
      end
    end

    // R6 normal vs deep
    for (int d = 0; d < 2; d++) begin
      go_sleep(d[0]);
      chk("R6 sleep core", core_clk_en, 0);
      chk("R6 sleep io/pwr", {io_clk_en, pwr_en}, d[0] ? 2'b00 : 2'b11);
      wake0();
      chk("R6 after wake io/pwr", {io_clk_en, pwr_en, core_clk_en}, 3'b111);
    end

    // R7 R8: exhaustive wake masks
    for (int r = 0; r < 16; r++) begin
      for (int e = 0; e < 16; e++) begin
        go_sleep(0);
        wake_req = r[3:0]; wake_en = e[3:0];
        tick();
        if ((r & e) != 0) begin
          exp_wc = r[3:0] & e[3:0];
          chk("R7 wake cause", wake_cause, exp_wc);
          chk("R8 hint_clr in wake", {hint_clr, core_clk_en}, 2'b10);
          wake_req = '0; wake_en = '0; lp_hint = 0;
          tick();
          chk("R8 clock back", {hint_clr, core_clk_en}, 2'b01);
        end else begin
          chk("R7 masked no wake", {hint_clr, core_clk_en}, 2'b00);
          chk("R7 cause held", wake_cause, exp_wc);
          wake0();
        end
      end
    end

    // R9: exhaustive reset masks in active
    for (int r = 0; r < 4; r++) begin
      for (int e = 0; e < 4; e++) begin
        rst_req = r[1:0]; rst_en = e[1:0];
        tick();
        if ((r & e) != 0) begin
          exp_rc = {1'b0, r[1:0] & e[1:0]};
          chk("R9 reset_req", {reset_req, core_clk_en}, 2'b11);
        end else chk("R9 masked reset", reset_req, 0);
        chk("R9 reset cause", reset_cause, exp_rc);
        rst_req = '0; rst_en = '0;
        tick();
        chk("R9 release", reset_req, 0);
      end
    end

    // R10: reset during check, entry, sleep
    for (int s = 1; s <= 3; s++) begin
      cpu_wfi = 1; lp_hint = 1;
      tick(); cpu_wfi = 0;
      for (int k = 1; k < s; k++) tick();
      rst_req = 2'b10; rst_en = 2'b10;
      tick();
      chk("R10 takeover", {reset_req, core_clk_en, reset_cause}, {2'b11, 3'b010});
      rst_req = '0; rst_en = '0; lp_hint = 0;
      tick();
      chk("R10 back active", {reset_req, core_clk_en}, 2'b01);
      go_sleep(0);
      chk("R10 sleeps again", core_clk_en, 0);
      wake0();
    end

    // R11: power loss from active, check, entry, sleep, wake
    for (int s = 0; s <= 4; s++) begin
      if (s > 0) begin
        cpu_wfi = 1; lp_hint = 1;
        tick(); cpu_wfi = 0;
        for (int k = 1; k < s && k < 3; k++) tick();
        if (s == 4) begin
          wake_req = 4'b1000; wake_en = 4'b1000; tick();
          wake_req = '0; wake_en = '0; exp_wc = 4'b1000;
          chk("R11 in wake", hint_clr, 1);
        end
      end
      main_pok = 0;
      tick();
      chk("R11 power fault", {reset_req, core_clk_en, reset_cause}, {2'b11, 3'b100});
      tick(); tick();
      chk("R11 held", reset_req, 1);
      main_pok = 1; lp_hint = 0;
      tick();
      chk("R11 recover", {reset_req, core_clk_en}, 2'b01);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule